// File: doc/BRIEF.md
# USB Low-Speed Preamble Transmit Sequencer

This block turns a byte stream from a USB link into a sequence of line-state symbols (J, K, SE0 or released). In ordinary full-speed mode it prepends a SYNC to the link's bytes, sends every bit at the full-speed rate, and closes with an end-of-packet. When the transceiver-select field asks for low-speed traffic through a hub, each packet is sent in two parts. The first part is a full-speed header: a SYNC followed by the PRE PID. The block then drives J for one full-speed bit and releases the bus, which gives a four-bit gap. The second part is the link's packet, with its own SYNC, sent at one eighth of the rate.

Serial bits are NRZI coded. A zero is inserted after every six consecutive ones. Bit timing comes from an external full-speed bit enable, and the low-speed part advances once every eight enables. Bytes are pulled with a valid/ready handshake at byte boundaries. If the link runs dry in the middle of a packet, the packet is aborted with a run of ones that is not stuffed.

FSM states: IDLE (released, waiting for valid), HSYNC and HPID (full-speed header), HOLDJ (one driven J bit), GAP (released bits), BSYNC and BDATA (packet SYNC and bytes), ABORT (unstuffed ones) and EOP (SE0, SE0, J, release). Transitions: IDLE→HSYNC when valid in preamble mode, otherwise IDLE→BSYNC; HSYNC→HPID→HOLDJ→GAP→BSYNC; BSYNC/BDATA→BDATA when a byte is taken; BSYNC/BDATA→EOP after the last byte; BSYNC/BDATA→ABORT on underrun; ABORT→EOP; EOP→IDLE.

Top module: `usb_pre_tx_seq`

## Requirements
- R1: Preamble mode is used for a packet exactly when `xcvr_sel` equals 2'b11 in the cycle the packet starts. Any other value gives single-rate full-speed sending. A change of `xcvr_sel` during a packet has no effect on that packet.
- R2: In preamble mode the packet opens with 16 bits at one bit per enable: the SYNC byte 0x80 and then the PRE PID 0x3C, each sent LSB first. No end-of-packet follows them.
- R3: After the last PRE PID bit the line shows J for exactly one full-speed bit and then release for three full-speed bits. The first low-speed SYNC bit starts on the next enable.
- R4: In preamble mode the body (SYNC 0x80, then the link bytes LSB first) holds each bit for eight full-speed enables.
- R5: Line symbols use the encoding SE0=2'b00, J=2'b01, K=2'b10, release=2'b11. Serial bits are NRZI coded: a 0 toggles between J and K and a 1 keeps the level. Each part (header, body) starts from J.
- R6: After six consecutive ones a stuffed zero is sent. This also applies after the final body bit, where the stuffed bit comes before the end-of-packet.
- R7: A packet ends with SE0 for two bit times and J for one bit time, at the rate of the part that was being sent. The line is then released and the block is idle.
- R8: In full-speed mode the SYNC and the bytes are sent at one bit per enable, with no header and no gap.
- R9: `tx_ready` is high only on the enable where the last bit of the SYNC or of the current byte completes. Exactly one byte is taken per byte sent, with `tx_ready` and `tx_valid` both high.
- R10: If `tx_valid` is low at a byte boundary before a byte marked last has been taken, the line holds its level for eight bit times with no stuffing. The end-of-packet of R7 follows.
- R11: During and after reset the line is released and `tx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xcvr_sel | input | 2 | Transceiver select; 2'b11 selects preamble mode |
| fs_bit_en | input | 1 | One-cycle strobe per full-speed bit time |
| tx_data | input | 8 | Packet byte from the link |
| tx_valid | input | 1 | `tx_data` holds a byte |
| tx_last | input | 1 | The byte on `tx_data` ends the packet |
| tx_ready | output | 1 | The byte is taken on this cycle |
| line_out | output | 2 | Line symbol (SE0/J/K/release) |

## Verification
A stale shift register or a wrong bit index puts a wrong J/K symbol on `line_out` at the very next bit enable. A miscounted gap or divider shifts every later symbol of the packet, so the symbol-by-symbol scoreboard catches it within one bit time. A lost stuffing count shows up as a missing or extra toggle within seven bits. A broken byte handshake shows up in two ways: as a wrong count of bytes taken, or as a packet that never ends.

// File: rtl/usb_pre_pkg.sv
package usb_pre_pkg;

    typedef enum logic [1:0] {
        SYM_SE0 = 2'b00,
        SYM_J   = 2'b01,
        SYM_K   = 2'b10,
        SYM_REL = 2'b11
    } line_sym_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HSYNC,
        S_HPID,
        S_HOLDJ,
        S_GAP,
        S_BSYNC,
        S_BDATA,
        S_ABORT,
        S_EOP
    } seq_state_t;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam logic [7:0] PRE_BYTE  = 8'h3C;
    localparam logic [1:0] PRE_SEL   = 2'b11;

    function automatic line_sym_t lvl_sym(input logic lvl);
        return lvl ? SYM_J : SYM_K;
    endfunction

endpackage

// File: rtl/usb_pre_bitclk.sv
module usb_pre_bitclk #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_bit_en,
    input  logic slow,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_q;

    assign tick = fs_bit_en && (!slow || div_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!slow) begin
            div_q <= '0;
        end else if (fs_bit_en) begin
            div_q <= (div_q == DW'(DIV - 1)) ? '0 : div_q + 1'b1;
        end
    end

    // R4: a slow bit never lasts a single cycle
    p_slow_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slow && tick) |=> (!tick || !slow));

endmodule

// File: rtl/usb_pre_nrzi_stuff.sv
module usb_pre_nrzi_stuff #(
    parameter int RUN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic bit_in,
    input  logic stuff_en,
    output logic stuff_due,
    output logic lvl_nxt
);
    localparam int OW = $clog2(RUN + 2);
    localparam logic [OW-1:0] OMAX = OW'(RUN + 1);

    logic          lvl_q;
    logic [OW-1:0] ones_q, ones_d;

    assign stuff_due = stuff_en && (ones_q == OW'(RUN));

    always_comb begin
        lvl_nxt = lvl_q;
        ones_d  = ones_q;
        if (step) begin
            if (stuff_due || !bit_in) begin
                lvl_nxt = !lvl_q;
                ones_d  = '0;
            end else if (ones_q != OMAX) begin
                ones_d  = ones_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= 1'b1;
            ones_q <= '0;
        end else if (clear) begin
            lvl_q  <= 1'b1;
            ones_q <= '0;
        end else begin
            lvl_q  <= lvl_nxt;
            ones_q <= ones_d;
        end
    end

    p_stuff_toggles_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && stuff_due && !clear) |=> (lvl_q != $past(lvl_q)));

    p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(lvl_q));

endmodule

// File: rtl/usb_pre_tx_seq.sv
module usb_pre_tx_seq
    import usb_pre_pkg::*;
#(
    parameter int GAP_BITS   = 4,
    parameter int LS_DIV     = 8,
    parameter int STUFF_RUN  = 6,
    parameter int ABORT_BITS = 8,
    parameter int EOP_SE0    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] xcvr_sel,
    input  logic       fs_bit_en,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    input  logic       tx_last,
    output logic       tx_ready,
    output logic [1:0] line_out
);
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = $clog2(BYTE_W);
    localparam int CNT_TOP = (ABORT_BITS > GAP_BITS) ? ABORT_BITS : GAP_BITS;
    localparam int CW      = $clog2(CNT_TOP + EOP_SE0 + 2);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(BYTE_W - 1);

    seq_state_t        state_q, state_d;
    line_sym_t         line_q, line_d;
    logic [BYTE_W-1:0] sh_q, sh_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [CW-1:0]     cnt_q, cnt_d;
    logic              pre_q, pre_d;
    logic              last_q, last_d;

    logic tick, slow, serial, body;
    logic enc_clear, enc_step, enc_bit, stuff_en, stuff_due, lvl_nxt;

    assign serial = (state_q == S_HSYNC) || (state_q == S_HPID) ||
                    (state_q == S_BSYNC) || (state_q == S_BDATA);
    assign body   = (state_q == S_BSYNC) || (state_q == S_BDATA);
    assign slow   = pre_q && (body || state_q == S_ABORT || state_q == S_EOP);

    assign enc_clear = (state_q == S_IDLE) || (state_q == S_HOLDJ) || (state_q == S_GAP);
    assign stuff_en  = (state_q != S_ABORT);
    assign enc_bit   = (state_q == S_ABORT) ? 1'b1 : sh_q[0];
    assign enc_step  = tick && (serial || state_q == S_ABORT ||
                                (state_q == S_EOP && stuff_due));

    assign tx_ready = tick && body && !stuff_due && (idx_q == IDX_END) && !last_q;
    assign line_out = line_q;

    usb_pre_bitclk #(.DIV(LS_DIV)) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs_bit_en(fs_bit_en),
        .slow     (slow),
        .tick     (tick)
    );

    usb_pre_nrzi_stuff #(.RUN(STUFF_RUN)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (enc_clear),
        .step     (enc_step),
        .bit_in   (enc_bit),
        .stuff_en (stuff_en),
        .stuff_due(stuff_due),
        .lvl_nxt  (lvl_nxt)
    );

    // next-state and output symbol
    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        sh_d    = sh_q;
        idx_d   = idx_q;
        cnt_d   = cnt_q;
        pre_d   = pre_q;
        last_d  = last_q;
        unique case (state_q)
            S_IDLE: begin
                line_d = SYM_REL;
                if (tx_valid) begin
                    pre_d   = (xcvr_sel == PRE_SEL);
                    state_d = (xcvr_sel == PRE_SEL) ? S_HSYNC : S_BSYNC;
                    sh_d    = SYNC_BYTE;
                    idx_d   = '0;
                    last_d  = 1'b0;
                end
            end
            S_HSYNC, S_HPID, S_BSYNC, S_BDATA: begin
                if (tick) begin
                    line_d = lvl_sym(lvl_nxt);
                    if (!stuff_due) begin
                        sh_d  = sh_q >> 1;
                        idx_d = idx_q + 1'b1;
                        if (idx_q == IDX_END) begin
                            if (state_q == S_HSYNC) begin
                                state_d = S_HPID;
                                sh_d    = PRE_BYTE;
                            end else if (state_q == S_HPID) begin
                                state_d = S_HOLDJ;
                            end else if (last_q) begin
                                state_d = S_EOP;
                                cnt_d   = '0;
                            end else if (tx_valid) begin
                                state_d = S_BDATA;
                                sh_d    = tx_data;
                                last_d  = tx_last;
                            end else begin
                                state_d = S_ABORT;
                                cnt_d   = '0;
                            end
                        end
                    end
                end
            end
            S_HOLDJ: begin
                if (tick) begin
                    line_d  = SYM_J;
                    state_d = S_GAP;
                    cnt_d   = '0;
                end
            end
            S_GAP: begin
                if (tick) begin
                    line_d = SYM_REL;
                    cnt_d  = cnt_q + 1'b1;
                    if (cnt_q == CW'(GAP_BITS - 2)) begin
                        state_d = S_BSYNC;
                        sh_d    = SYNC_BYTE;
                        idx_d   = '0;
                    end
                end
            end
            S_ABORT: begin
                if (tick) begin
                    line_d = lvl_sym(lvl_nxt);
                    cnt_d  = cnt_q + 1'b1;
                    if (cnt_q == CW'(ABORT_BITS - 1)) begin
                        state_d = S_EOP;
                        cnt_d   = '0;
                    end
                end
            end
            S_EOP: begin
                if (tick) begin
                    if (stuff_due) begin
                        line_d = lvl_sym(lvl_nxt);
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q < CW'(EOP_SE0)) begin
                            line_d = SYM_SE0;
                        end else if (cnt_q == CW'(EOP_SE0)) begin
                            line_d = SYM_J;
                        end else begin
                            line_d  = SYM_REL;
                            state_d = S_IDLE;
                        end
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            line_q  <= SYM_REL;
            sh_q    <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
            pre_q   <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
            sh_q    <= sh_d;
            idx_q   <= idx_d;
            cnt_q   <= cnt_d;
            pre_q   <= pre_d;
            last_q  <= last_d;
        end
    end

    p_mode_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && $past(state_q) != S_IDLE) |-> $stable(pre_q));

    p_hold_j_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GAP && $past(state_q) == S_HOLDJ) |-> (line_q == SYM_J));

    p_eop_j_before_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && $past(state_q) == S_EOP) |-> ($past(line_q) == SYM_J));

    p_take_starts_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && tx_valid) |=> (state_q == S_BDATA && idx_q == '0));

    p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (line_q == SYM_REL && !tx_ready));

endmodule

// File: tb/usb_pre_tx_seq_bench.sv
module usb_pre_tx_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] SE0 = 2'b00, SJ = 2'b01, SK = 2'b10, REL = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] xcvr_sel = 2'b00;
    logic       fs_bit_en = 1'b0;
    logic       en_d = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_last = 1'b0;
    logic       tx_ready;
    logic [1:0] line_out;

    int  n_chk = 0, n_bad = 0, n_cons = 0, cyc = 0;
    bit  armed = 1'b0;
    logic [1:0] exp_sym[$];
    string      exp_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_pre_tx_seq u_usb_pre_tx_seq (
        .clk(clk), .rst_n(rst_n), .xcvr_sel(xcvr_sel), .fs_bit_en(fs_bit_en),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
        .tx_ready(tx_ready), .line_out(line_out)
    );

    always @(posedge clk) begin
        en_d      <= fs_bit_en;
        fs_bit_en <= !fs_bit_en;
        cyc       <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: compare each bit-time symbol against the scoreboard
    always @(negedge clk) begin
        if (tx_ready && tx_valid) n_cons++;
        if (en_d && exp_sym.size() != 0) begin
            if (!armed && line_out != REL) armed = 1'b1;
            if (armed) begin
                logic [1:0] s;
                string t;
                s = exp_sym.pop_front();
                t = exp_tag.pop_front();
                check(line_out === s, t, int'(line_out), int'(s));
                if (exp_sym.size() == 0) armed = 1'b0;
            end
        end
    end

    task automatic push(input logic [1:0] s, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_sym.push_back(s);
            exp_tag.push_back(tag);
        end
    endtask

    task automatic add_byte(ref bit q[$], input logic [7:0] v);
        for (int i = 0; i < 8; i++) q.push_back(v[i]);
    endtask

    // R5 NRZI from J, R6 stuffing after six ones
    task automatic enc_bits(input bit bits[$], input int rate, input string tag, output bit lvl_o);
        bit lvl = 1'b1;
        int ones = 0;
        foreach (bits[i]) begin
            if (!bits[i]) begin lvl = !lvl; ones = 0; end
            else ones++;
            push(lvl ? SJ : SK, rate, tag);
            if (ones == 6) begin
                lvl = !lvl; ones = 0;
                push(lvl ? SJ : SK, rate, "R6");
            end
        end
        lvl_o = lvl;
    endtask

    task automatic expect_packet(input bit pre, input logic [7:0] d[4], input int n_give,
                                 input bit underrun);
        int rate = pre ? 8 : 1;
        bit lv;
        bit h[$];
        bit b[$];
        if (pre) begin
            add_byte(h, 8'h80);
            add_byte(h, 8'h3C);
            enc_bits(h, 1, "R2", lv);
            push(SJ, 1, "R3");
            push(REL, 3, "R3");
        end
        add_byte(b, 8'h80);
        for (int i = 0; i < n_give; i++) add_byte(b, d[i]);
        enc_bits(b, rate, pre ? "R4" : "R8", lv);
        if (underrun) push(lv ? SJ : SK, 8 * rate, "R10");
        push(SE0, 2 * rate, "R7");
        push(SJ, rate, "R7");
        push(REL, 1, "R7");
    endtask

    task automatic send(input logic [1:0] sel, input logic [7:0] d[4], input int n_give,
                        input bit underrun, input bit flip_sel);
        int c0;
        expect_packet(sel == 2'b11, d, n_give, underrun);
        @(negedge clk);
        c0 = n_cons;
        xcvr_sel = sel;
        for (int i = 0; i < n_give; i++) begin
            tx_valid = 1'b1;
            tx_data  = d[i];
            tx_last  = !underrun && (i == n_give - 1);
            do @(negedge clk); while (!tx_ready);
            @(negedge clk);
            if (flip_sel && i == 0) xcvr_sel = ~sel;  // R1: ignored mid-packet
        end
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        while (exp_sym.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(n_cons - c0 == n_give, "R9 bytes taken", n_cons - c0, n_give);
        check(line_out == REL && !tx_ready, "R7 idle after packet", int'(line_out), int'(REL));
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(line_out == REL, "R11 line in reset", int'(line_out), int'(REL));
        check(tx_ready == 1'b0, "R11 ready in reset", int'(tx_ready), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(line_out == REL, "R11 line after reset", int'(line_out), int'(REL));
        // R8 full-speed, plain data
        send(2'b00, '{8'hA5, 8'h3C, 8'h00, 8'h00}, 2, 1'b0, 1'b0);
        // R6 full-speed stuffing incl. trailing stuff before EOP
        send(2'b00, '{8'hFF, 8'hFC, 8'h00, 8'h00}, 2, 1'b0, 1'b0);
        // R1 other select values stay single rate
        send(2'b01, '{8'h12, 8'h00, 8'h00, 8'h00}, 1, 1'b0, 1'b0);
        send(2'b10, '{8'hE7, 8'h00, 8'h00, 8'h00}, 1, 1'b0, 1'b0);
        // R1 R2 R3 R4 preamble packet with select flipped mid-packet
        send(2'b11, '{8'hC3, 8'h01, 8'h80, 8'h00}, 3, 1'b0, 1'b1);
        // R6 stuffing at low speed
        send(2'b11, '{8'hFF, 8'hFC, 8'h00, 8'h00}, 2, 1'b0, 1'b0);
        // R10 underrun at low speed and at full speed
        send(2'b11, '{8'h2D, 8'h00, 8'h00, 8'h00}, 1, 1'b1, 1'b0);
        send(2'b00, '{8'h4B, 8'h00, 8'h00, 8'h00}, 1, 1'b1, 1'b0);
        finish_run();
    end

endmodule